// File: doc/BRIEF.md
# Serial Line Loopback Selector

This block sits between a serial transmitter, a serial receiver and the line pins. A 3-bit test-mode field decides where the receiver gets its data and clock, where the transmitter gets its clock, and what appears on the outgoing data pin. The field can select three things. Transmit data can be routed back into the receiver. Both line clocks can be taken from an internal divide-by-eight of the system clock in place of the external clocks. The outgoing data pin can be held at all ones, so the line sees idle while an internal loop test runs.

The internal line clock is built in the system clock domain. It is a 50% duty square wave with a period of `DIV_RATIO` system clocks, which can drive the pins. A one-cycle enable strobe marks the start of each high phase, for logic that runs on the system clock. The mode field is captured into an active-mode register only on the last count of the divider period, so a new mode always starts on a whole internal clock period. Every routing decision follows the active mode, not the raw input.

Top module: `loopback_selector`

## Requirements
- R1: While reset is asserted, the active mode is normal operation, the divider count is zero and the internal clock and strobe are both high.
- R2: In the active codes 0, 1, 2 and 3, the receiver takes data and clock from the external receive pins, the transmitter takes the external transmit clock, and the data pin carries the internal transmit data.
- R3: The internal clock is high for divider counts 0 to `DIV_RATIO/2-1` and low for the rest, with a period of `DIV_RATIO` system clocks (8 by default). The divider runs in every mode. The strobe is high exactly on count 0.
- R4: The mode input is sampled only at the rising system clock edge that ends divider count `DIV_RATIO-1`, and it takes effect from count 0. Changes at any other edge leave the outputs unaffected until then.
- R5: When bit 2 of the active code is 1 (codes 4 to 7), the receive data output equals the internal transmit data and the external receive data is ignored.
- R6: In active codes 4 and 6, both the receive clock and the transmit clock come from the external transmit clock input.
- R7: In active codes 5 and 7 (bit 2 and bit 0 set), both the receive clock and the transmit clock equal the internal divided clock.
- R8: In active codes 6 and 7 (bit 2 and bit 1 set), the data pin is 1 whatever the transmit data. In all other codes it carries the transmit data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Requested loopback code |
| ext_tx_clk_i | input | 1 | External transmit clock |
| ext_rx_clk_i | input | 1 | External receive clock |
| ext_rx_data_i | input | 1 | External receive data |
| tx_data_i | input | 1 | Internal transmit data |
| rx_data_o | output | 1 | Data to the receiver |
| rx_clk_o | output | 1 | Clock to the receiver |
| tx_clk_o | output | 1 | Clock to the transmitter |
| tx_pin_o | output | 1 | Outgoing line data pin |
| line_ce_o | output | 1 | One-cycle strobe at the start of each internal clock period |

## Verification
The assertions assume that `mode_i` is stable around each rising system clock edge, so it is sampled cleanly, and that reset is released away from a clock edge. They also take the external clocks and data to be plain level inputs that are only routed, never sampled. The bench therefore changes every input, including the external clocks, on the falling system clock edge. It varies the mode at several divider phases so that the sampling at the end of the period is exercised, and it draws the external levels at random.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    // Decoded view of the loopback code
    typedef struct packed {
        logic loop;      // transmit data returns into receiver
        logic silent;    // outgoing pin held at ones
        logic internal;  // both line clocks from divider
    } route_t;

    function automatic route_t decode_mode(input logic [2:0] code);
        route_t r;
        r.loop     = code[2];
        r.silent   = code[2] & code[1];
        r.internal = code[2] & code[0];
        return r;
    endfunction

endpackage

// File: rtl/lbs_clkdiv.sv
module lbs_clkdiv #(
    parameter int DIV_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_clk_o,
    output logic tick_o,
    output logic wrap_o
);
    localparam int CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV_RATIO / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sq;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == LAST) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
        div_d.sq = (div_d.cnt < HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '{cnt: '0, sq: 1'b1};
        end else begin
            div_q <= div_d;
        end
    end

    assign div_clk_o = div_q.sq;
    assign tick_o    = (div_q.cnt == '0);
    assign wrap_o    = (div_q.cnt == LAST);

    // R3: counter stays inside its period
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.cnt <= LAST);
    // R3: square wave rises only at the start of a period
    a_r3_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_q.sq) |-> tick_o);
    // R3: square wave falls only at mid period
    a_r3_fall_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_q.sq) |-> (div_q.cnt == HALF));

endmodule

// File: rtl/lbs_router.sv
module lbs_router
    import lbs_pkg::*;
(
    input  route_t sel_i,
    input  logic   div_clk_i,
    input  logic   ext_tx_clk_i,
    input  logic   ext_rx_clk_i,
    input  logic   ext_rx_data_i,
    input  logic   tx_data_i,
    output logic   rx_data_o,
    output logic   rx_clk_o,
    output logic   tx_clk_o,
    output logic   tx_pin_o
);
    always_comb begin
        rx_data_o = sel_i.loop ? tx_data_i : ext_rx_data_i;
        tx_clk_o  = sel_i.internal ? div_clk_i : ext_tx_clk_i;
        if (sel_i.internal) begin
            rx_clk_o = div_clk_i;
        end else if (sel_i.loop) begin
            rx_clk_o = ext_tx_clk_i;
        end else begin
            rx_clk_o = ext_rx_clk_i;
        end
        tx_pin_o = sel_i.silent ? 1'b1 : tx_data_i;
    end
endmodule

// File: rtl/loopback_selector.sv
module loopback_selector
    import lbs_pkg::*;
#(
    parameter int DIV_RATIO = 8
) (
    input  logic       sys_clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       ext_tx_clk_i,
    input  logic       ext_rx_clk_i,
    input  logic       ext_rx_data_i,
    input  logic       tx_data_i,
    output logic       rx_data_o,
    output logic       rx_clk_o,
    output logic       tx_clk_o,
    output logic       tx_pin_o,
    output logic       line_ce_o
);
    typedef struct packed {
        route_t act;
    } sel_t;

    sel_t sel_d, sel_q;
    logic div_clk, tick, wrap;

    lbs_clkdiv #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .div_clk_o (div_clk),
        .tick_o    (tick),
        .wrap_o    (wrap)
    );

    always_comb begin
        sel_d = sel_q;
        if (wrap) begin
            sel_d.act = decode_mode(mode_i);
        end
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '{act: decode_mode(3'b000)};
        end else begin
            sel_q <= sel_d;
        end
    end

    lbs_router u_route (
        .sel_i         (sel_q.act),
        .div_clk_i     (div_clk),
        .ext_tx_clk_i  (ext_tx_clk_i),
        .ext_rx_clk_i  (ext_rx_clk_i),
        .ext_rx_data_i (ext_rx_data_i),
        .tx_data_i     (tx_data_i),
        .rx_data_o     (rx_data_o),
        .rx_clk_o      (rx_clk_o),
        .tx_clk_o      (tx_clk_o),
        .tx_pin_o      (tx_pin_o)
    );

    assign line_ce_o = tick;

    // R4: active mode moves only into count zero
    a_r4_load_at_wrap: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !$stable(sel_q) |-> tick);
    // R5: loop codes return transmit data to the receiver
    a_r5_loop_data: assert property (@(posedge sys_clk) disable iff (!rst_n)
        sel_q.act.loop |-> (rx_data_o == tx_data_i));
    // R7: internal clocking gives both line clocks the same source
    a_r7_shared_clk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        sel_q.act.internal |-> (rx_clk_o == tx_clk_o) && (tx_clk_o == div_clk));
    // R8: silent codes idle the line pin
    a_r8_silent_ones: assert property (@(posedge sys_clk) disable iff (!rst_n)
        sel_q.act.silent |-> tx_pin_o);
    // R3: strobe coincides with the high half of the internal clock
    a_r3_strobe_high: assert property (@(posedge sys_clk) disable iff (!rst_n)
        line_ce_o |-> div_clk);

endmodule

// File: tb/loopback_selector_test.sv
module loopback_selector_test;
    logic       sys_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       ext_tx_clk_i = 1'b0;
    logic       ext_rx_clk_i = 1'b0;
    logic       ext_rx_data_i = 1'b0;
    logic       tx_data_i = 1'b0;
    logic       rx_data_o, rx_clk_o, tx_clk_o, tx_pin_o, line_ce_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt = 0;
    int m_act = 0;

    always #10 sys_clk = ~sys_clk;

    loopback_selector uut (
        .sys_clk       (sys_clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .ext_tx_clk_i  (ext_tx_clk_i),
        .ext_rx_clk_i  (ext_rx_clk_i),
        .ext_rx_data_i (ext_rx_data_i),
        .tx_data_i     (tx_data_i),
        .rx_data_o     (rx_data_o),
        .rx_clk_o      (rx_clk_o),
        .tx_clk_o      (tx_clk_o),
        .tx_pin_o      (tx_pin_o),
        .line_ce_o     (line_ce_o)
    );

    always @(posedge sys_clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_act = 0;
        end else begin
            if (m_cnt == 7) m_act = int'(mode_i);
            m_cnt = (m_cnt + 1) % 8;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic ic, ercv, etck, erck, epin;
        int lp, sl, in;
        ic = (m_cnt < 4);
        lp = (m_act >> 2) & 1;
        sl = lp & ((m_act >> 1) & 1);
        in = lp & (m_act & 1);
        ercv = lp ? tx_data_i : ext_rx_data_i;
        etck = in ? ic : ext_tx_clk_i;
        erck = in ? ic : (lp ? ext_tx_clk_i : ext_rx_clk_i);
        epin = sl ? 1'b1 : tx_data_i;
        chk("R3", "line_ce", line_ce_o, (m_cnt == 0));
        chk(lp ? "R5" : "R2", "rx_data", rx_data_o, ercv);
        chk(in ? "R7" : (lp ? "R6" : "R2"), "tx_clk", tx_clk_o, etck);
        chk(in ? "R7" : (lp ? "R6" : "R2"), "rx_clk", rx_clk_o, erck);
        chk(sl ? "R8" : "R2", "tx_pin", tx_pin_o, epin);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge sys_clk);
            ext_tx_clk_i  = 1'($urandom);
            ext_rx_clk_i  = 1'($urandom);
            ext_rx_data_i = 1'($urandom);
            tx_data_i     = 1'($urandom);
            #1;
            compare_all();
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge sys_clk);
        // R1: reset state seen at the pins, with opposing external levels
        ext_rx_data_i = 1'b1; tx_data_i = 1'b0; ext_rx_clk_i = 1'b1; ext_tx_clk_i = 1'b0;
        #1;
        chk("R1", "line_ce", line_ce_o, 1'b1);
        chk("R1", "rx_data", rx_data_o, 1'b1);
        chk("R1", "rx_clk", rx_clk_o, 1'b1);
        chk("R1", "tx_pin", tx_pin_o, 1'b0);
        rst_n = 1'b1;
        step(20);
        // every code, changed at differing divider phases (R4)
        for (int m = 0; m < 8; m++) begin
            mode_i = 3'(m);
            step(13 + 3 * m);
        end
        // R4: request a loop code mid-period and watch pins hold until wrap
        mode_i = 3'd0;
        step(16);
        while (m_cnt != 2) step(1);
        @(negedge sys_clk);
        mode_i = 3'd6;
        tx_data_i = 1'b0;
        #1;
        chk("R4", "tx_pin before wrap", tx_pin_o, 1'b0);
        step(12);
        chk("R4", "tx_pin after wrap", tx_pin_o, 1'b1);
        // rapid toggling between codes inside one period (R4)
        for (int k = 0; k < 40; k++) begin
            mode_i = 3'($urandom);
            step(1 + (k % 5));
        end
        for (int m = 7; m >= 0; m--) begin
            mode_i = 3'(m);
            step(24);
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule